// File: doc/BRIEF.md
# General-Purpose Register Bank with Hard-Wired Zero Register

This block holds the working registers of a simple load/store processor datapath. It has 32 registers of 32 bits, two combinational read ports and one write port that is sampled on the rising clock edge. The block takes the three 5-bit register fields of the current instruction as separate inputs and builds its own read and write addresses from them. Port A always reads the register named by the first source field. Port B reads either the second source field or the destination field. Reading the destination field is how a store instruction fetches the value it writes to memory.

Register 31 is a constant zero. Each read port compares the address that its own multiplexer produced against 31 and returns zero when they match, so a store that names register 31 as its data source sends out zero. The write address is either the destination field or the fixed exception-pointer register 30. The processor uses register 30 to save a return address when an interrupt or a trap occurs. A zero flag on port A supports conditional-branch decisions.

A high level on the synchronous reset blocks every write. The storage array itself has no reset, so the block can map onto distributed RAM.

Top module: `gpr_bank`

## Requirements
- R1: `rd_a` returns, in the same cycle, the register addressed by `fld_ra`.
- R2: `rd_b` returns the register addressed by `fld_rb` when `sel_b_rc` is 0, and the register addressed by `fld_rc` when `sel_b_rc` is 1.
- R3: When `fld_ra` equals 31, `rd_a` is 0 regardless of what the array holds at index 31.
- R4: Port B forces zero from its selected address: with `sel_b_rc`=1, `fld_rb`=31 and `fld_rc`≠31, `rd_b` returns the stored data; with `fld_rc`=31 and `fld_rb`≠31, it returns 0.
- R5: With `wr_en`=1, `rst`=0 and `sel_wr_xp`=0, the rising edge stores `wr_data` at index `fld_rc`, and reads return the new value from the next cycle on.
- R6: With `sel_wr_xp`=1, the write goes to register 30 and the register named by `fld_rc` keeps its value.
- R7: With `wr_en`=0, no register changes.
- R8: A write addressed to register 31 is accepted but never becomes visible on either read port.
- R9: `a_zero` is 1 exactly when all 32 bits of `rd_a` are 0, including when `fld_ra` is 31.
- R10: While `rst`=1, no write takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the write happens on the rising edge |
| rst | input | 1 | Synchronous active-high reset; blocks writes |
| fld_ra | input | 5 | First source register field |
| fld_rb | input | 5 | Second source register field |
| fld_rc | input | 5 | Destination register field |
| sel_b_rc | input | 1 | Port B address select: 0 selects fld_rb, 1 selects fld_rc |
| sel_wr_xp | input | 1 | Write address select: 0 selects fld_rc, 1 selects register 30 |
| wr_en | input | 1 | Write enable |
| wr_data | input | 32 | Data to write |
| rd_a | output | 32 | Port A read data |
| rd_b | output | 32 | Port B read data |
| a_zero | output | 1 | High when rd_a is all zeros |

## Verification
A corrupted array entry or a wrong address path shows up at the data outputs in the first cycle that the affected register is read. Reads have no latency, so the error appears in the same cycle as the address. A write that goes to the wrong index shows up one cycle after its edge, either as a stale value at the intended register or as changed data at another register. For that reason the bench reads every register back on both ports and under both port B selections. A zero forced from the wrong address differs from the correct behaviour only when the second source field and the destination field disagree about index 31, so both of those mixed cases are driven directly.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam int unsigned GPR_AW    = 5;
  localparam int unsigned GPR_DEPTH = 1 << GPR_AW;

  typedef logic [GPR_AW-1:0] gpr_idx_t;

  typedef struct packed {
    gpr_idx_t rd_a;
    gpr_idx_t rd_b;
    gpr_idx_t wr;
  } gpr_addr_t;
endpackage

// File: rtl/gpr_addr_sel.sv
module gpr_addr_sel
  import gpr_pkg::*;
#(
  parameter int unsigned XP_IDX = 30
) (
  input  gpr_idx_t  fld_ra,
  input  gpr_idx_t  fld_rb,
  input  gpr_idx_t  fld_rc,
  input  logic      sel_b_rc,
  input  logic      sel_wr_xp,
  output gpr_addr_t addr
);
  localparam gpr_idx_t XP_ADDR = gpr_idx_t'(XP_IDX);

  always_comb begin
    addr.rd_a = fld_ra;
    addr.rd_b = sel_b_rc ? fld_rc : fld_rb;
    addr.wr   = sel_wr_xp ? XP_ADDR : fld_rc;
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store
  import gpr_pkg::*;
#(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = GPR_DEPTH
) (
  input  logic          clk,
  input  logic          we,
  input  gpr_idx_t      waddr,
  input  logic [DW-1:0] wdata,
  input  gpr_idx_t      raddr_a,
  input  gpr_idx_t      raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/gpr_zero_mask.sv
module gpr_zero_mask
  import gpr_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned ZERO_IDX = 31
) (
  input  gpr_idx_t      addr,
  input  logic [DW-1:0] raw,
  output logic [DW-1:0] data
);
  localparam gpr_idx_t ZERO_ADDR = gpr_idx_t'(ZERO_IDX);

  assign data = (addr == ZERO_ADDR) ? '0 : raw;
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank
  import gpr_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned ZERO_IDX = 31,
  parameter int unsigned XP_IDX   = 30
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [GPR_AW-1:0]    fld_ra,
  input  logic [GPR_AW-1:0]    fld_rb,
  input  logic [GPR_AW-1:0]    fld_rc,
  input  logic                 sel_b_rc,
  input  logic                 sel_wr_xp,
  input  logic                 wr_en,
  input  logic [DW-1:0]        wr_data,
  output logic [DW-1:0]        rd_a,
  output logic [DW-1:0]        rd_b,
  output logic                 a_zero
);
  localparam int unsigned NPORT = 2;

  gpr_addr_t     addr;
  logic [DW-1:0] raw  [NPORT];
  logic [DW-1:0] outp [NPORT];
  gpr_idx_t      radr [NPORT];

  gpr_addr_sel #(.XP_IDX(XP_IDX)) u_sel (
    .fld_ra(fld_ra), .fld_rb(fld_rb), .fld_rc(fld_rc),
    .sel_b_rc(sel_b_rc), .sel_wr_xp(sel_wr_xp), .addr(addr)
  );

  assign radr[0] = addr.rd_a;
  assign radr[1] = addr.rd_b;

  gpr_store #(.DW(DW), .DEPTH(GPR_DEPTH)) u_store (
    .clk(clk), .we(wr_en & ~rst), .waddr(addr.wr), .wdata(wr_data),
    .raddr_a(radr[0]), .raddr_b(radr[1]),
    .rdata_a(raw[0]), .rdata_b(raw[1])
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    gpr_zero_mask #(.DW(DW), .ZERO_IDX(ZERO_IDX)) u_mask (
      .addr(radr[p]), .raw(raw[p]), .data(outp[p])
    );
  end

  assign rd_a   = outp[0];
  assign rd_b   = outp[1];
  assign a_zero = ~|outp[0];
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic [4:0]  fld_ra,
  input logic [4:0]  fld_rb,
  input logic [4:0]  fld_rc,
  input logic        sel_b_rc,
  input logic        sel_wr_xp,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_a,
  input logic [31:0] rd_b,
  input logic        a_zero
);
  // R3
  ra_zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    fld_ra == 5'd31 |-> rd_a == 32'd0);

  // R4
  rb_zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
    ((sel_b_rc ? fld_rc : fld_rb) == 5'd31) |-> rd_b == 32'd0);

  // R9
  zflag_match_chk: assert property (@(posedge clk) disable iff (rst)
    a_zero == (rd_a == 32'd0));

  // R5
  write_visible_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && !rst && !sel_wr_xp && fld_rc != 5'd31) && fld_ra == $past(fld_rc))
      |-> rd_a == $past(wr_data));

  // R6
  xp_write_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(wr_en && !rst && sel_wr_xp) && fld_ra == 5'd30) |-> rd_a == $past(wr_data));

  // R7
  no_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(!wr_en && !rst) && $stable(fld_ra)) |-> $stable(rd_a));
endmodule

bind gpr_bank gpr_bank_chk u_chk (.*);

// File: tb/sim_gpr_bank.sv
`timescale 1ns/100ps
module sim_gpr_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  fld_ra = '0, fld_rb = '0, fld_rc = '0;
  logic        sel_b_rc = 1'b0, sel_wr_xp = 1'b0, wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_a, rd_b;
  logic        a_zero;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [32];

  always #2.5 clk = ~clk;

  gpr_bank u0 (.*);

  function automatic logic [31:0] ex(input int i);
    return (i == 31) ? 32'd0 : model[i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input int rc, input logic [31:0] d, input logic xp, input logic en);
    @(negedge clk);
    fld_rc = 5'(rc); wr_data = d; sel_wr_xp = xp; wr_en = en;
    @(negedge clk);
    wr_en = 1'b0; sel_wr_xp = 1'b0;
  endtask

  task automatic rd(input int ra, input int rb, input int rc, input logic sb);
    fld_ra = 5'(ra); fld_rb = 5'(rb); fld_rc = 5'(rc); sel_b_rc = sb;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // reset state: R3 and R9 hold while in reset
    rd(31, 31, 0, 1'b0);
    chk("R3 reset", rd_a, 32'd0);
    chk("R9 reset", {31'd0, a_zero}, 32'd1);
    @(negedge clk);
    rst = 1'b0;

    // R5: sweep writes to every index through the destination field
    for (int i = 0; i < 32; i++) begin
      model[i] = 32'h9E3779B9 * (i + 1);
      wr(i, model[i], 1'b0, 1'b1);
    end

    // R1 R2 R3 R8 R9: read all indices on both ports, both selections
    for (int i = 0; i < 32; i++) begin
      rd(i, i, 31 - i, 1'b0);
      chk("R1 read A", rd_a, ex(i));
      chk("R2 read B via rb", rd_b, ex(i));
      chk("R9 zflag", {31'd0, a_zero}, {31'd0, ex(i) == 32'd0});
      rd(i, i, 31 - i, 1'b1);
      chk("R2 read B via rc", rd_b, ex(31 - i));
      @(negedge clk);
    end

    // R4: zero forced from the selected address only
    rd(0, 31, 7, 1'b1);
    chk("R4 rb31 rc7", rd_b, model[7]);
    rd(0, 7, 31, 1'b1);
    chk("R4 rb7 rc31", rd_b, 32'd0);
    rd(0, 31, 7, 1'b0);
    chk("R4 rb31 sel rb", rd_b, 32'd0);

    // R6: write redirected to register 30
    wr(4, 32'hC0FFEE01, 1'b1, 1'b1);
    model[30] = 32'hC0FFEE01;
    rd(30, 4, 0, 1'b0);
    chk("R6 reg30", rd_a, model[30]);
    chk("R6 rc untouched", rd_b, model[4]);

    // R7: write enable low
    wr(9, 32'h12345678, 1'b0, 1'b0);
    rd(9, 9, 9, 1'b1);
    chk("R7 no write A", rd_a, model[9]);
    chk("R7 no write B", rd_b, model[9]);

    // R8: write to register 31 not visible
    wr(31, 32'hFFFFFFFF, 1'b0, 1'b1);
    rd(31, 0, 31, 1'b1);
    chk("R8 A", rd_a, 32'd0);
    chk("R8 B", rd_b, 32'd0);
    chk("R8 zflag", {31'd0, a_zero}, 32'd1);

    // R9: stored zero sets flag
    wr(12, 32'd0, 1'b0, 1'b1);
    model[12] = 32'd0;
    rd(12, 0, 0, 1'b0);
    chk("R9 stored zero", {31'd0, a_zero}, 32'd1);
    chk("R5 overwrite", rd_a, 32'd0);
    rd(13, 0, 0, 1'b0);
    chk("R9 nonzero", {31'd0, a_zero}, 32'd0);

    // R10: writes blocked during reset
    @(negedge clk);
    rst = 1'b1;
    wr(2, 32'hBAD0BAD0, 1'b0, 1'b1);
    rst = 1'b0;
    rd(2, 2, 0, 1'b0);
    chk("R10 blocked A", rd_a, model[2]);
    chk("R10 blocked B", rd_b, model[2]);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule